// File: doc/BRIEF.md
# AAL5 Segmentation Engine

This block turns one user PDU, delivered as a byte stream, into a run of 48-byte cell payloads. The PDU is framed with zero fill and an eight-byte trailer, so the framed length is always a whole number of cells. The trailer holds two zero bytes, the 16-bit user byte count, and a CRC-32. The CRC covers the user bytes, the fill and the first four trailer bytes. Each 48-byte chunk is a complete cell payload and carries no extra framing. A separate cell-header builder downstream uses the per-byte start and end-of-payload markers and the end-of-PDU flag to build the headers.

Bytes come in on a ready/valid stream with first and last markers and go out on a ready/valid byte stream. Internally the block fills a single 48-byte cell buffer and then drains it. While it drains, and while it generates fill and trailer bytes, it holds its input ready low. A PDU that grows past the configured maximum length is dropped. The bytes of the cell being assembled are discarded, the rest of that PDU is consumed without output, no closing cell is produced, and an error pulse is raised.

Top module: `aal5_segmenter`

## Requirements
- R1: During and right after reset, out_valid and err_oversize are low and in_ready is high.
- R2: Output bytes come in groups of exactly 48. out_sol is high on byte 0 of each group and out_eol on byte 47. A PDU of L bytes gives ceil((L+8)/48)*48 output bytes.
- R3: The user bytes appear first in the output, unchanged and in arrival order.
- R4: Directly after the user bytes come (40 - L mod 48) mod 48 fill bytes, all 0x00, so that the trailer's final byte is byte 47 of a cell.
- R5: The eight trailer bytes are, in order: 0x00, 0x00, L[15:8], L[7:0], then the four CRC bytes. L counts user bytes only.
- R6: The CRC is CRC-32 with generator 0x04C11DB7. It is processed most significant bit first, starts from 0xFFFFFFFF and covers user, fill, zero and length bytes. It is sent inverted, most significant byte first.
- R7: out_eop is high on all 48 bytes of the payload that holds the trailer and low on every other output byte.
- R8: in_ready is low from the acceptance of a PDU's last byte until the closing cell has fully drained, and in_ready and out_valid are never high together.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_eop, out_sol and out_eol do not change.
- R10: When a byte would make a PDU longer than MAX_PDU, that byte, the partly filled cell and all later bytes up to in_last are dropped. No further cells are produced for the PDU. err_oversize is high for exactly one cycle, the cycle after in_last is accepted.
- R11: A byte accepted with in_first high starts a new PDU, and any bytes of an unfinished PDU still held in the partial cell are dropped.
- R12: Once a PDU has completed or been rejected, the next PDU is accepted and framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| in_data | input | 8 | User byte |
| in_first | input | 1 | Byte is the first of a PDU |
| in_last | input | 1 | Byte is the last of a PDU |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Cell payload byte |
| out_sol | output | 1 | Byte 0 of a 48-byte payload |
| out_eol | output | 1 | Byte 47 of a 48-byte payload |
| out_eop | output | 1 | Payload carries the trailer (end of PDU) |
| err_oversize | output | 1 | One-cycle pulse: PDU rejected as too long |

## Verification
The checker counts output handshakes from reset. It assumes every payload starts at a cell boundary, so a marker placed off by one byte shows up as a mismatch against that count. The properties assume that out_ready may drop at any cycle and that in_valid may have gaps, and the bench drives both with deterministic on/off patterns that include long stalls. The bench sets in_first only on the first byte of a PDU, except in one deliberate restart case. It asserts in_last only when it means to end a PDU, so every flag the properties rely on has a single legal meaning during the sweep.

// File: rtl/aal5_seg_pkg.sv
`timescale 1ns/1ps
package aal5_seg_pkg;

   localparam int CELL_BYTES = 48;
   localparam int TRL_BYTES  = 8;
   localparam int TRL_START  = CELL_BYTES - TRL_BYTES;
   localparam int POS_W      = $clog2(CELL_BYTES);

   typedef enum logic [1:0] {
      ST_FILL  = 2'd0,
      ST_TAIL  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_FLUSH = 2'd3
   } seg_state_t;

   // one byte through a left-shifting CRC-32 register
   function automatic logic [31:0] crc32_msb_byte(input logic [31:0] cur,
                                                  input logic [7:0]  din,
                                                  input logic [31:0] poly);
      logic [31:0] r;
      r = cur ^ {din, 24'h000000};
      for (int i = 0; i < 8; i++) begin
         r = r[31] ? ((r << 1) ^ poly) : (r << 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/aal5_crc32.sv
`timescale 1ns/1ps
module aal5_crc32
   import aal5_seg_pkg::*;
#(
   parameter logic [31:0] POLY = 32'h04C11DB7,
   parameter logic [31:0] SEED = 32'hFFFFFFFF
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        restart,
   input  logic [7:0]  din,
   output logic [31:0] rem
);

   logic [31:0] rem_q;
   logic [31:0] base;

   assign base = restart ? SEED : rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= SEED;
      end else if (en) begin
         rem_q <= crc32_msb_byte(base, din, POLY);
      end else if (restart) begin
         rem_q <= SEED;
      end
   end

   assign rem = rem_q;

endmodule

// File: rtl/aal5_cell_buf.sv
`timescale 1ns/1ps
module aal5_cell_buf #(
   parameter int BYTES = 48,
   parameter int DW    = 8,
   localparam int AW   = $clog2(BYTES)
)(
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] slot [BYTES];

   always_ff @(posedge clk) begin
      if (we) begin
         slot[waddr] <= wdata;
      end
   end

   assign rdata = slot[raddr];

endmodule

// File: rtl/aal5_segmenter.sv
`timescale 1ns/1ps
module aal5_segmenter
   import aal5_seg_pkg::*;
#(
   parameter int          MAX_PDU  = 65535,
   parameter logic [31:0] CRC_POLY = 32'h04C11DB7,
   localparam int         CNT_W    = $clog2(MAX_PDU + 1)
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_first,
   input  logic       in_last,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data,
   output logic       out_sol,
   output logic       out_eol,
   output logic       out_eop,
   output logic       err_oversize
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);
   localparam logic [POS_W-1:0] TRL_POS  = POS_W'(TRL_START);

   // elaboration-time parameter checks
   if (MAX_PDU < 1 || MAX_PDU > 65535) begin : g_bad_max
      $error("MAX_PDU must lie in 1..65535 to fit the 16-bit length field");
   end
   if (TRL_START % 8 != 0) begin : g_bad_trl
      $error("trailer start must be a multiple of 8 for the slot index decode");
   end

   seg_state_t        state_q, state_d;
   logic [POS_W-1:0]  pos_q, pos_d;
   logic [POS_W-1:0]  rd_q, rd_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              trl_ok_q, trl_ok_d;
   logic              eop_q, eop_d;
   logic              ret_tail_q, ret_tail_d;
   logic              err_q, err_d;

   logic              fill_st, acc, over;
   logic [POS_W-1:0]  wpos;
   logic [CNT_W-1:0]  base_cnt;
   logic              wr_full;
   logic              in_trl, crc_slot;
   logic [2:0]        tidx;
   logic [15:0]       len16;
   logic [7:0]        tail_byte;
   logic              buf_we;
   logic [7:0]        buf_wdata;
   logic [7:0]        buf_rdata;
   logic              crc_en, crc_restart;
   logic [31:0]       crc_rem;

   // input side decode
   assign fill_st  = (state_q == ST_FILL);
   assign in_ready = fill_st || (state_q == ST_FLUSH);
   assign acc      = in_valid && in_ready;
   assign wpos     = (fill_st && in_first) ? '0 : pos_q;
   assign base_cnt = (fill_st && in_first) ? '0 : cnt_q;
   assign over     = (base_cnt == CNT_W'(MAX_PDU));
   assign wr_full  = (wpos == LAST_POS);

   // tail generation: fill until the trailer window, then 8 trailer slots
   assign in_trl   = trl_ok_q && (pos_q >= TRL_POS);
   assign tidx     = pos_q[2:0];
   assign crc_slot = in_trl && tidx[2];
   assign len16    = 16'(cnt_q);

   always_comb begin
      tail_byte = 8'h00;
      if (in_trl) begin
         case (tidx)
            3'd2:    tail_byte = len16[15:8];
            3'd3:    tail_byte = len16[7:0];
            3'd4:    tail_byte = ~crc_rem[31:24];
            3'd5:    tail_byte = ~crc_rem[23:16];
            3'd6:    tail_byte = ~crc_rem[15:8];
            3'd7:    tail_byte = ~crc_rem[7:0];
            default: tail_byte = 8'h00;
         endcase
      end
   end

   assign buf_we    = (fill_st && acc && !over) || (state_q == ST_TAIL);
   assign buf_wdata = (state_q == ST_TAIL) ? tail_byte : in_data;

   // next-state logic
   always_comb begin
      state_d     = state_q;
      pos_d       = pos_q;
      rd_d        = rd_q;
      cnt_d       = cnt_q;
      trl_ok_d    = trl_ok_q;
      eop_d       = eop_q;
      ret_tail_d  = ret_tail_q;
      err_d       = 1'b0;
      crc_en      = 1'b0;
      crc_restart = 1'b0;
      unique case (state_q)
         ST_FILL: begin
            if (acc) begin
               if (over) begin
                  pos_d       = '0;
                  cnt_d       = '0;
                  crc_restart = 1'b1;
                  if (in_last) err_d = 1'b1;
                  else         state_d = ST_FLUSH;
               end else begin
                  crc_en      = 1'b1;
                  crc_restart = in_first;
                  cnt_d       = base_cnt + 1'b1;
                  pos_d       = wr_full ? '0 : wpos + 1'b1;
                  if (in_last) trl_ok_d = wr_full || (wpos < TRL_POS);
                  if (wr_full) begin
                     state_d    = ST_DRAIN;
                     ret_tail_d = in_last;
                  end else if (in_last) begin
                     state_d = ST_TAIL;
                  end
               end
            end
         end
         ST_TAIL: begin
            crc_en = !crc_slot;
            pos_d  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            if (pos_q == LAST_POS) begin
               state_d    = ST_DRAIN;
               eop_d      = in_trl;
               ret_tail_d = !in_trl;
               trl_ok_d   = 1'b1;
            end
         end
         ST_DRAIN: begin
            if (out_ready) begin
               if (rd_q == LAST_POS) begin
                  rd_d = '0;
                  if (eop_q) begin
                     state_d     = ST_FILL;
                     cnt_d       = '0;
                     eop_d       = 1'b0;
                     trl_ok_d    = 1'b0;
                     ret_tail_d  = 1'b0;
                     crc_restart = 1'b1;
                  end else begin
                     state_d = ret_tail_q ? ST_TAIL : ST_FILL;
                  end
               end else begin
                  rd_d = rd_q + 1'b1;
               end
            end
         end
         ST_FLUSH: begin
            if (acc && in_last) begin
               err_d   = 1'b1;
               state_d = ST_FILL;
            end
         end
         default: state_d = ST_FILL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_FILL;
         pos_q      <= '0;
         rd_q       <= '0;
         cnt_q      <= '0;
         trl_ok_q   <= 1'b0;
         eop_q      <= 1'b0;
         ret_tail_q <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         state_q    <= state_d;
         pos_q      <= pos_d;
         rd_q       <= rd_d;
         cnt_q      <= cnt_d;
         trl_ok_q   <= trl_ok_d;
         eop_q      <= eop_d;
         ret_tail_q <= ret_tail_d;
         err_q      <= err_d;
      end
   end

   aal5_crc32 #(
      .POLY (CRC_POLY),
      .SEED (32'hFFFFFFFF)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (crc_en),
      .restart (crc_restart),
      .din     (buf_wdata),
      .rem     (crc_rem)
   );

   aal5_cell_buf #(
      .BYTES (CELL_BYTES),
      .DW    (8)
   ) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .waddr (wpos),
      .wdata (buf_wdata),
      .raddr (rd_q),
      .rdata (buf_rdata)
   );

   // output side
   assign out_valid    = (state_q == ST_DRAIN);
   assign out_data     = buf_rdata;
   assign out_sol      = out_valid && (rd_q == '0);
   assign out_eol      = out_valid && (rd_q == LAST_POS);
   assign out_eop      = out_valid && eop_q;
   assign err_oversize = err_q;

endmodule

// File: rtl/aal5_segmenter_chk.sv
`timescale 1ns/1ps
module aal5_segmenter_chk
   import aal5_seg_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_sol,
   input logic       out_eol,
   input logic       out_eop,
   input logic       err_oversize
);

   logic [POS_W-1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (out_valid && out_ready) begin
         beat_q <= (beat_q == POS_W'(CELL_BYTES - 1)) ? '0 : beat_q + 1'b1;
      end
   end

   // R2
   sol_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sol == (beat_q == '0)));

   // R2
   eol_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_eol == (beat_q == POS_W'(CELL_BYTES - 1))));

   // R7
   eop_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_eol) |=> (out_valid && $stable(out_eop)));

   // R8
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R8
   reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_eol && out_eop) |=> (in_ready && !out_valid));

   // R9
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)
                                     && $stable(out_sol) && $stable(out_eol)));

   // R10
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_oversize |=> !err_oversize);

endmodule

bind aal5_segmenter aal5_segmenter_chk u_chk (.*);

// File: tb/aal5_segmenter_test.sv
`timescale 1ns/1ps
module aal5_segmenter_test;

   localparam int MAXP = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       in_first = 1'b0;
   logic       in_last = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_data;
   logic       out_sol, out_eol, out_eop, err_oversize;

   int n_chk = 0;
   int n_fail = 0;
   int wd_cyc = 0;

   logic [7:0] gotb [0:511];
   logic       gote [0:511];

   always #2.5 clk = ~clk;

   aal5_segmenter #(.MAX_PDU(MAXP)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_first(in_first), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sol(out_sol), .out_eol(out_eol), .out_eop(out_eop),
      .err_oversize(err_oversize)
   );

   always @(posedge clk) begin
      wd_cyc++;
      if (wd_cyc == 150000) begin
         n_fail++;
         $display("FAIL R2 watchdog expired: actual %0d cycles expected fewer", wd_cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i, input int salt);
      return 8'((i * 37 + salt * 11 + 5) ^ (i >> 3));
   endfunction

   function automatic int total_of(input int len);
      return ((len + 8 + 47) / 48) * 48;
   endfunction

   // expected byte before the CRC slots
   function automatic logic [7:0] pre_byte(input int i, input int len, input int salt);
      int t = total_of(len);
      if (i < len)    return pat(i, salt);
      if (i == t - 6) return 8'(len >> 8);
      if (i == t - 5) return 8'(len);
      return 8'h00;
   endfunction

   function automatic logic [31:0] ref_crc(input int len, input int salt);
      logic [31:0] c = 32'hFFFFFFFF;
      int body = total_of(len) - 4;
      for (int i = 0; i < body; i++) begin
         logic [7:0] b = pre_byte(i, len, salt);
         for (int k = 7; k >= 0; k--) begin
            logic fb = c[31] ^ b[k];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
         end
      end
      return ~c;
   endfunction

   // sends bytes without a closing marker (aborted PDU)
   task automatic send_partial(input int cnt);
      int sent = 0;
      while (sent < cnt) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = pat(sent, 99);
         in_first = (sent == 0);
         in_last  = 1'b0;
         if (in_ready) sent++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
   endtask

   task automatic run_pdu(input int len, input int salt, input bit expect_err);
      int sent = 0, got = 0, cyc = 0, errs = 0;
      int bad_mark = 0, bad_r8 = 0, bad_hold = 0, stray = 0;
      bit fin = 1'b0, hold_pend = 1'b0;
      logic [7:0] hold_d = 8'h00;
      int t = total_of(len);
      logic [31:0] crc = ref_crc(len, salt);
      while (!fin && cyc < 5000) begin
         @(negedge clk);
         if (err_oversize) errs++;
         if (hold_pend && !(out_valid && out_data == hold_d)) bad_hold++;
         if (!expect_err && sent == len && in_ready) bad_r8++;
         if (in_ready && out_valid) bad_r8++;
         if (sent < len && ((cyc + len) % 7) != 3) begin
            in_valid = 1'b1;
            in_data  = pat(sent, salt);
            in_first = (sent == 0);
            in_last  = (sent == len - 1);
            if (in_ready) sent++;
         end else begin
            in_valid = 1'b0;
            in_first = 1'b0;
            in_last  = 1'b0;
         end
         out_ready = (((cyc * 3 + len) % 5) != 1);
         hold_pend = out_valid && !out_ready;
         hold_d    = out_data;
         if (out_valid && out_ready && got < 512) begin
            if (out_sol != ((got % 48) == 0) || out_eol != ((got % 48) == 47)) bad_mark++;
            gotb[got] = out_data;
            gote[got] = out_eop;
            got++;
            if (out_eol && out_eop) fin = 1'b1;
         end
         if (expect_err && errs > 0 && sent == len) fin = 1'b1;
         cyc++;
      end
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; out_ready = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (out_valid) stray++;
         if (err_oversize) errs++;
      end
      check(cyc < 5000, "R2", "PDU finished in time", cyc, 5000);
      check(bad_mark == 0, "R2", "sol/eol marker positions", bad_mark, 0);
      check(bad_hold == 0, "R9", "output held under backpressure", bad_hold, 0);
      check(bad_r8 == 0, "R8", "input closed during tail and drain", bad_r8, 0);
      check(in_ready == 1'b1, "R12", "input open after PDU", in_ready, 1);
      if (expect_err) begin
         int exp_got = ((MAXP / 48) * 48);
         int bad_d = -1;
         for (int i = 0; i < got; i++) if (gotb[i] !== pat(i, salt) && bad_d < 0) bad_d = i;
         check(got == exp_got, "R10", "cells before rejection", got, exp_got);
         check(bad_d < 0, "R10", "data of cells before rejection", bad_d, -1);
         check(errs == 1, "R10", "single error pulse", errs, 1);
         check(stray == 0, "R10", "no output after rejection", stray, 0);
         for (int i = 0; i < got; i++)
            check(gote[i] == 1'b0, "R10", "no end-of-PDU cell", gote[i], 0);
      end else begin
         int bad_d = -1, bad_p = -1, bad_e = -1;
         logic [7:0] e6, e7;
         check(got == t, "R2", "framed byte total", got, t);
         for (int i = 0; i < len && i < got; i++)
            if (gotb[i] !== pat(i, salt) && bad_d < 0) bad_d = i;
         check(bad_d < 0, "R3", "user bytes in order", bad_d, -1);
         for (int i = len; i < t - 8 && i < got; i++)
            if (gotb[i] !== 8'h00 && bad_p < 0) bad_p = i;
         check(bad_p < 0, "R4", "fill bytes zero and counted", bad_p, -1);
         if (got == t) begin
            e6 = 8'(len >> 8);
            e7 = 8'(len);
            check({gotb[t-8], gotb[t-7]} == 16'h0000, "R5", "reserved bytes",
                  {gotb[t-8], gotb[t-7]}, 0);
            check({gotb[t-6], gotb[t-5]} == {e6, e7}, "R5", "length field",
                  {gotb[t-6], gotb[t-5]}, {e6, e7});
            check({gotb[t-4], gotb[t-3], gotb[t-2], gotb[t-1]} == crc, "R6", "CRC-32",
                  {gotb[t-4], gotb[t-3], gotb[t-2], gotb[t-1]}, crc);
            for (int i = 0; i < t; i++)
               if (gote[i] != (i >= t - 48) && bad_e < 0) bad_e = i;
            check(bad_e < 0, "R7", "end-of-PDU flag span", bad_e, -1);
         end
         check(errs == 0, "R10", "no error on legal PDU", errs, 0);
         check(stray == 0, "R8", "no output after closing cell", stray, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && err_oversize == 1'b0, "R1", "outputs idle in reset",
            {out_valid, err_oversize}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      check(err_oversize == 1'b0, "R1", "err after reset", err_oversize, 0);

      // sweep every legal length in the small configuration (R3..R7)
      for (int len = 1; len <= MAXP; len++) run_pdu(len, len, 1'b0);

      // oversize rejection and recovery (R10, R12)
      run_pdu(MAXP + 1, 7, 1'b1);
      run_pdu(5, 3, 1'b0);
      run_pdu(MAXP + 50, 8, 1'b1);
      run_pdu(48, 9, 1'b0);

      // aborted PDU followed by a fresh start marker (R11)
      send_partial(10);
      run_pdu(30, 21, 1'b0);
      send_partial(45);
      run_pdu(41, 22, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule